// File: doc/BRIEF.md
# NPU Output Post-Processing Pipeline

This block is a streaming stage that follows an integer dot-product array in a neural accelerator. Each input beat carries `LANES` signed 32-bit accumulator sums, which come from 8x8-bit integer products. The stages always run in the same order. First a selectable activation is applied to every lane. Next, adjacent lane pairs can be pooled, which halves the lane count. Each value is then requantized to a signed byte. Last, a write buffer gathers the bytes into words of `OUT_BYTES` bytes, ready for writeback to on-chip SRAM.

Both edges of the block use valid/ready handshakes. The pipeline accepts one beat per cycle for as long as its output is not stalled. When the output is stalled, every stage holds its contents, so no data is lost or repeated. A beat flagged as end-of-layer forces out the word being built, even if it is only partly filled. The unfilled bytes are zero and are cleared in the byte-enable mask. The activation, pooling and shift controls are sampled with each beat and must stay constant within a layer.

Top module: `npu_post_pipe`

## Requirements
- R1: While reset is high, and at the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Activation code 0 passes each accumulator unchanged. Code 1 (ReLU) replaces negative values with 0 and passes the rest unchanged.
- R3: Codes 2 (SiLU) and 3 (TanH) first clamp the accumulator to [-128, 127], read as fixed point x/16, and then look up a 256-entry table. SiLU gives `trunc0(x*clamp(x+48,0,96)/96)`. TanH on |x| gives |x| up to 8, then `8+trunc((|x|-8)/2)` up to 24, then 16, and the sign is restored.
- R4: Pool code 1 writes the maximum of lanes 2k and 2k+1 to lane k. Code 2 writes floor((a+b)/2) to lane k. Codes 0 and 3 leave the lanes unpooled. Pooling works on activation results and yields LANES/2 bytes per beat.
- R5: Requantization shifts right by `rq_shift` (0 to 31), rounds halves away from zero, and saturates to [-128, 127].
- R6: Bytes fill a word from byte 0 upward: lane 0 of the oldest beat takes the lowest byte. A word holding `OUT_BYTES` bytes is emitted with every byte-enable bit set, and `out_last` is 0 unless that beat ended the layer.
- R7: An end-of-layer beat emits the current word with `out_last` = 1. Bytes past the fill point are zero, and `out_be` has bits set only for the filled low bytes.
- R8: While `out_valid` is high and `out_ready` is low, the word, the mask and `out_last` stay stable and `in_ready` is 0. Every word is delivered exactly once, in order.
- R9: While `out_ready` is high, `in_ready` is high, so one beat is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_acc | input | LANES*32 | Accumulators, lane 0 in the low bits |
| in_last | input | 1 | Beat ends the layer |
| act_mode | input | 2 | 0 pass, 1 ReLU, 2 SiLU, 3 TanH |
| pool_mode | input | 2 | 0 none, 1 pair max, 2 pair average, 3 none |
| rq_shift | input | 5 | Requantization right shift |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | OUT_BYTES*8 | Packed bytes, byte 0 in the low bits |
| out_be | output | OUT_BYTES | Byte-enable mask |
| out_last | output | 1 | Word closes the layer |

## Verification
The bench uses the defaults of four lanes and 16-byte words. An unpooled word therefore fills in four beats and a pooled word in eight. This puts every fill level of a flushed word, both full-word paths and mixed pooled and unpooled layers within a few dozen beats. The small lane count also means the table lookups, the rounding ties at shift 1 and the shift-31 corner can be aimed at directly. Random output backpressure then exercises the stall path against a behavioural model that works on queues.

// File: rtl/npu_post_pkg.sv
package npu_post_pkg;

  typedef enum logic [1:0] {
    ACT_PASS = 2'b00,
    ACT_RELU = 2'b01,
    ACT_SILU = 2'b10,
    ACT_TANH = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    POOL_OFF = 2'b00,
    POOL_MAX = 2'b01,
    POOL_AVG = 2'b10
  } pool_e;

  localparam int LUT_OUT_W = 16;
  localparam int SHIFT_W   = 5;

  // Hard-sigmoid weighted input, Q4.4 in and out, truncation toward zero.
  function automatic logic signed [LUT_OUT_W-1:0] silu_pt(input int x);
    int g;
    g = x + 48;
    if (g < 0) g = 0;
    if (g > 96) g = 96;
    return LUT_OUT_W'((x * g) / 96);
  endfunction

  // Three-segment odd curve saturating at 1.0 (16 in Q4.4).
  function automatic logic signed [LUT_OUT_W-1:0] tanh_pt(input int x);
    int m, y;
    m = (x < 0) ? -x : x;
    if (m <= 8) y = m;
    else if (m <= 24) y = 8 + (m - 8) / 2;
    else y = 16;
    return LUT_OUT_W'((x < 0) ? -y : y);
  endfunction

  // Shift, round half away from zero, clamp to a signed byte.
  function automatic logic signed [7:0] requant(input logic signed [32:0] v,
                                               input logic [SHIFT_W-1:0] s);
    logic        neg;
    logic signed [33:0] w;
    logic [33:0] mag, rnd, r;
    neg = v[32];
    w   = 34'(v);
    mag = neg ? 34'(-w) : 34'(w);
    rnd = (s == '0) ? 34'd0 : (34'd1 << (s - 1'b1));
    r   = (mag + rnd) >> s;
    if (!neg) return (r > 34'd127) ? 8'sd127 : 8'(r);
    return (r > 34'd128) ? -8'sd128 : 8'(~r + 34'd1);
  endfunction

endpackage

// File: rtl/npu_act_lane.sv
module npu_act_lane
  import npu_post_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic [1:0]              act_in,
  input  logic [1:0]              act_q,
  output logic signed [ACC_W-1:0] y
);
  localparam int LUT_N = 512;
  localparam logic signed [ACC_W-1:0] LIM_HI = 127;
  localparam logic signed [ACC_W-1:0] LIM_LO = -128;

  logic signed [LUT_OUT_W-1:0] rom [LUT_N];
  logic signed [LUT_OUT_W-1:0] lut_q;
  logic signed [ACC_W-1:0]     acc_q;
  logic [7:0]                  idx;

  initial begin
    for (int i = 0; i < LUT_N; i++) begin
      int xi;
      xi = (i % 256) - (((i % 256) >= 128) ? 256 : 0);
      rom[i] = (i >= 256) ? tanh_pt(xi) : silu_pt(xi);
    end
  end

  always_comb begin
    if (acc_in > LIM_HI)      idx = 8'h7f;
    else if (acc_in < LIM_LO) idx = 8'h80;
    else                      idx = acc_in[7:0];
  end

  // Unreset registered read so the table can map onto block RAM.
  always_ff @(posedge clk) begin
    if (en) begin
      lut_q <= rom[{act_in[0], idx}];
      acc_q <= acc_in;
    end
  end

  always_comb begin
    case (act_q)
      ACT_PASS: y = acc_q;
      ACT_RELU: y = (acc_q < 0) ? '0 : acc_q;
      default:  y = {{(ACC_W-LUT_OUT_W){lut_q[LUT_OUT_W-1]}}, lut_q};
    endcase
  end
endmodule

// File: rtl/npu_pool_quant.sv
module npu_pool_quant
  import npu_post_pkg::*;
#(
  parameter int LANES = 4,
  parameter int ACC_W = 32,
  localparam int NBW  = $clog2(LANES + 1)
) (
  input  logic [LANES*ACC_W-1:0] act_flat,
  input  logic [1:0]             pool,
  input  logic [SHIFT_W-1:0]     shift,
  output logic [LANES*8-1:0]     bytes,
  output logic [NBW-1:0]         nb
);
  localparam int HALF = LANES / 2;

  logic pooling;
  assign pooling = (pool == POOL_MAX) || (pool == POOL_AVG);
  assign nb = pooling ? NBW'(HALF) : NBW'(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [ACC_W-1:0] own;
    logic signed [32:0]      sel;
    assign own = act_flat[k*ACC_W +: ACC_W];
    if (k < HALF) begin : g_pair
      logic signed [ACC_W-1:0] a, b;
      logic signed [32:0]      a33, b33, sum;
      assign a   = act_flat[(2*k)*ACC_W +: ACC_W];
      assign b   = act_flat[(2*k+1)*ACC_W +: ACC_W];
      assign a33 = 33'(a);
      assign b33 = 33'(b);
      assign sum = a33 + b33;
      always_comb begin
        if (pool == POOL_MAX)      sel = (a33 > b33) ? a33 : b33;
        else if (pool == POOL_AVG) sel = sum >>> 1;
        else                       sel = 33'(own);
      end
    end else begin : g_tail
      assign sel = pooling ? '0 : 33'(own);
    end
    assign bytes[k*8 +: 8] = requant(sel, shift);
  end
endmodule

// File: rtl/npu_wr_pack.sv
module npu_wr_pack #(
  parameter int LANES     = 4,
  parameter int OUT_BYTES = 16,
  localparam int NBW      = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   in_v,
  input  logic [LANES*8-1:0]     in_bytes,
  input  logic [NBW-1:0]         in_nb,
  input  logic                   in_last,
  output logic                   out_valid,
  output logic [OUT_BYTES*8-1:0] out_data,
  output logic [OUT_BYTES-1:0]   out_be,
  output logic                   out_last
);
  localparam int PW = $clog2(OUT_BYTES + 1);

  logic [7:0]           buf_q [OUT_BYTES];
  logic [7:0]           mrg   [OUT_BYTES];
  logic [PW-1:0]        ptr_q, fill;
  logic [OUT_BYTES-1:0] be_n;
  logic                 emit;

  always_comb begin
    fill = ptr_q + PW'(in_nb);
    for (int b = 0; b < OUT_BYTES; b++) begin
      mrg[b] = buf_q[b];
      for (int l = 0; l < LANES; l++) begin
        if ((NBW'(l) < in_nb) && (ptr_q + PW'(l) == PW'(b)))
          mrg[b] = in_bytes[l*8 +: 8];
      end
      be_n[b] = PW'(b) < fill;
    end
    emit = in_v && ((fill == PW'(OUT_BYTES)) || in_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      ptr_q     <= '0;
      for (int b = 0; b < OUT_BYTES; b++) buf_q[b] <= '0;
    end else if (en) begin
      out_valid <= emit;
      if (emit) begin
        for (int b = 0; b < OUT_BYTES; b++) out_data[b*8 +: 8] <= mrg[b];
        out_be   <= be_n;
        out_last <= in_last;
        ptr_q    <= '0;
        for (int b = 0; b < OUT_BYTES; b++) buf_q[b] <= '0;
      end else if (in_v) begin
        ptr_q <= fill;
        for (int b = 0; b < OUT_BYTES; b++) buf_q[b] <= mrg[b];
      end
    end
  end
endmodule

// File: rtl/npu_post_pipe.sv
module npu_post_pipe
  import npu_post_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int OUT_BYTES = 16,
  parameter int ACC_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*ACC_W-1:0] in_acc,
  input  logic                   in_last,
  input  logic [1:0]             act_mode,
  input  logic [1:0]             pool_mode,
  input  logic [SHIFT_W-1:0]     rq_shift,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_BYTES*8-1:0] out_data,
  output logic [OUT_BYTES-1:0]   out_be,
  output logic                   out_last
);
  localparam int NBW = $clog2(LANES + 1);

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: activation, per-beat controls travel alongside.
  logic                   v1, last1;
  logic [1:0]             act1, pool1;
  logic [SHIFT_W-1:0]     sh1;
  logic [LANES*ACC_W-1:0] act_flat;

  for (genvar l = 0; l < LANES; l++) begin : g_act
    npu_act_lane #(.ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .en     (adv),
      .acc_in (in_acc[l*ACC_W +: ACC_W]),
      .act_in (act_mode),
      .act_q  (act1),
      .y      (act_flat[l*ACC_W +: ACC_W])
    );
  end

  // Stage 2: pooling and requantization.
  logic [LANES*8-1:0] bytes_c, bytes2;
  logic [NBW-1:0]     nb_c, nb2;
  logic               v2, last2;

  npu_pool_quant #(.LANES(LANES), .ACC_W(ACC_W)) u_pq (
    .act_flat (act_flat),
    .pool     (pool1),
    .shift    (sh1),
    .bytes    (bytes_c),
    .nb       (nb_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      act1   <= act_mode;
      pool1  <= pool_mode;
      sh1    <= rq_shift;
      last1  <= in_last;
      bytes2 <= bytes_c;
      nb2    <= nb_c;
      last2  <= last1;
    end
  end

  // Stage 3: word aggregation with registered outputs.
  npu_wr_pack #(.LANES(LANES), .OUT_BYTES(OUT_BYTES)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .en        (adv),
    .in_v      (v2),
    .in_bytes  (bytes2),
    .in_nb     (nb2),
    .in_last   (last2),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_be    (out_be),
    .out_last  (out_last)
  );
endmodule

// File: rtl/npu_post_chk.sv
module npu_post_chk #(
  parameter int OUT_BYTES = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [OUT_BYTES*8-1:0] out_data,
  input logic [OUT_BYTES-1:0]   out_be,
  input logic                   out_last
);
  logic rst_d = 1'b0;
  logic pad_ok;

  always_ff @(posedge clk) rst_d <= rst;

  always_comb begin
    pad_ok = 1'b1;
    for (int b = 0; b < OUT_BYTES; b++)
      if (!out_be[b] && (out_data[b*8 +: 8] != 8'h00)) pad_ok = 1'b0;
  end

  // R1: idle output straight out of reset
  always @(posedge clk) begin
    if (rst_d) p_reset_idle_r1: assert (!out_valid && in_ready);
  end

  p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be) && $stable(out_last));

  p_stall_input_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_full_rate_r9: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  p_full_word_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> &out_be);

  p_mask_shape_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_be != '0) && ((out_be & (out_be + 1'b1)) == '0));

  p_zero_pad_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pad_ok);
endmodule

bind npu_post_pipe npu_post_chk #(.OUT_BYTES(OUT_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_be    (out_be),
  .out_last  (out_last)
);

// File: tb/sim_npu_post_pipe.sv
module sim_npu_post_pipe;
  localparam int LANES = 4;
  localparam int OB    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [LANES*32-1:0] in_acc = '0;
  logic [1:0] act_mode = 2'd0, pool_mode = 2'd0;
  logic [4:0] rq_shift = 5'd0;
  logic in_ready, out_valid, out_last;
  logic [OB*8-1:0] out_data;
  logic [OB-1:0]   out_be;

  always #4 clk = ~clk;

  npu_post_pipe #(.LANES(LANES), .OUT_BYTES(OB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_last(in_last), .act_mode(act_mode),
    .pool_mode(pool_mode), .rq_shift(rq_shift), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
    .out_last(out_last)
  );

  int n_tests = 0, n_fail = 0, stall_err = 0;
  bit bp_on = 0;
  logic [OB*8-1:0] q_data[$];
  logic [OB-1:0]   q_be[$];
  bit              q_last[$];
  string           q_tag[$];
  logic [7:0]      mb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [OB*8-1:0] act, input logic [OB*8-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int silu_ref(int x);
    int g = x + 48;
    if (g < 0) g = 0;
    if (g > 96) g = 96;
    return (x * g) / 96;
  endfunction

  function automatic int tanh_ref(int x);
    int m = (x < 0) ? -x : x;
    int y = (m <= 8) ? m : ((m <= 24) ? 8 + (m - 8) / 2 : 16);
    return (x < 0) ? -y : y;
  endfunction

  function automatic longint act_ref(int m, longint x);
    int xi = (x > 127) ? 127 : ((x < -128) ? -128 : int'(x));
    case (m)
      0: return x;
      1: return (x < 0) ? 0 : x;
      2: return silu_ref(xi);
      default: return tanh_ref(xi);
    endcase
  endfunction

  function automatic int rq_ref(longint v, int s);
    longint mag = (v < 0) ? -v : v;
    longint r = (s == 0) ? mag : ((mag + (longint'(1) << (s - 1))) >> s);
    longint q = (v < 0) ? -r : r;
    return (q > 127) ? 127 : ((q < -128) ? -128 : int'(q));
  endfunction

  task automatic model_beat(input logic [LANES*32-1:0] d, input int am, input int pm,
                            input int sh, input bit last, input string tag);
    longint a[LANES];
    for (int l = 0; l < LANES; l++) a[l] = act_ref(am, longint'($signed(d[l*32 +: 32])));
    if (pm == 1 || pm == 2) begin
      for (int k = 0; k < LANES / 2; k++) begin
        longint p = (pm == 1) ? ((a[2*k] > a[2*k+1]) ? a[2*k] : a[2*k+1])
                              : ((a[2*k] + a[2*k+1]) >>> 1);
        mb.push_back(8'(rq_ref(p, sh)));
      end
    end else begin
      for (int l = 0; l < LANES; l++) mb.push_back(8'(rq_ref(a[l], sh)));
    end
    if (mb.size() == OB || last) begin
      logic [OB*8-1:0] w = '0;
      logic [OB-1:0]   be = '0;
      for (int i = 0; i < mb.size(); i++) begin
        w[i*8 +: 8] = mb[i];
        be[i] = 1'b1;
      end
      mb.delete();
      q_data.push_back(w); q_be.push_back(be); q_last.push_back(last); q_tag.push_back(tag);
    end
  endtask

  task automatic step(input bit iv, input logic [LANES*32-1:0] d, input bit last,
                      input int am, input int pm, input int sh, input string tag,
                      output bit accepted);
    bit ordy;
    @(negedge clk);
    ordy = bp_on ? ($urandom_range(2) != 0) : 1'b1;
    in_valid = iv; in_acc = d; in_last = last;
    act_mode = 2'(am); pool_mode = 2'(pm); rq_shift = 5'(sh); out_ready = ordy;
    #1;
    if (ordy && !in_ready) stall_err++;
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R8", "unexpected word", out_data, '0);
      end else begin
        string t = q_tag.pop_front();
        logic [OB*8-1:0] ed = q_data.pop_front();
        logic [OB-1:0]   eb = q_be.pop_front();
        bit              el = q_last.pop_front();
        check(out_data == ed, t, "data", out_data, ed);
        check(out_be == eb, (eb == '1) ? "R6" : "R7", "mask", OB*8'(out_be), OB*8'(eb));
        check(out_last == el, el ? "R7" : "R6", "last", OB*8'(out_last), OB*8'(el));
      end
    end
    accepted = iv && in_ready;
    if (accepted) model_beat(d, am, pm, sh, last, tag);
  endtask

  task automatic send(input logic [LANES*32-1:0] d, input bit last, input int am,
                      input int pm, input int sh, input string tag);
    bit acc = 1'b0;
    while (!acc) step(1'b1, d, last, am, pm, sh, tag, acc);
  endtask

  function automatic logic [LANES*32-1:0] gen(int kind);
    logic [LANES*32-1:0] d;
    for (int l = 0; l < LANES; l++) begin
      int v;
      case (kind)
        0: v = int'($urandom());
        1: v = int'($urandom_range(400)) - 200;
        default: v = int'($urandom_range(16)) - 8;
      endcase
      d[l*32 +: 32] = 32'(v);
    end
    return d;
  endfunction

  task automatic phase(input string tag, input int am, input int pm, input int sh,
                       input int beats, input int kind);
    for (int i = 0; i < beats; i++) send(gen(kind), i == beats - 1, am, pm, sh, tag);
  endtask

  task automatic drain();
    bit dummy;
    for (int i = 0; i < 80 && (q_data.size() != 0 || out_valid); i++)
      step(1'b0, '0, 1'b0, 0, 0, 0, "R8", dummy);
  endtask

  function automatic logic [LANES*32-1:0] pack4(int a, int b, int c, int d);
    return {32'(d), 32'(c), 32'(b), 32'(a)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid in reset", OB*8'(out_valid), '0);
    check(in_ready, "R1", "in_ready in reset", OB*8'(in_ready), 1);
    @(negedge clk); rst = 1'b0;
    #1;
    check(!out_valid && in_ready, "R1", "idle after reset", OB*8'(out_valid), '0);

    phase("R2", 0, 0, 0, 5, 2);             // pass-through, small values
    phase("R2", 1, 0, 2, 6, 1);             // ReLU
    phase("R3", 2, 0, 0, 9, 1);             // SiLU table
    phase("R3", 3, 0, 0, 9, 1);             // TanH table
    phase("R3", 3, 3, 0, 3, 0);             // clamped index, pool code 3 unpooled
    phase("R4", 0, 1, 24, 9, 0);            // pair max
    phase("R4", 1, 2, 3, 5, 1);             // pair average after ReLU
    send(pack4(-3, 0, 5, -6), 0, 0, 2, 0, "R4");   // floor(-1.5)=-2, floor(-0.5)=-1
    send(pack4(-1, -1, 7, 8), 1, 0, 2, 0, "R4");
    // R5: ties at shift 1, saturation, shift 31
    send(pack4(3, -3, 1, -1), 0, 0, 0, 1, "R5");
    send(pack4(5, -5, 2, -2), 0, 0, 0, 1, "R5");
    send(pack4(1000, -1000, 127, -128), 0, 0, 0, 0, "R5");
    send(pack4(32'h7fffffff, 32'h80000000, 32'h40000000, 32'hc0000000), 1, 0, 0, 31, "R5");
    // R7: partial flushes at several fill levels
    send(pack4(11, 22, 33, 44), 1, 0, 0, 0, "R7");
    send(pack4(50, 60, 70, 80), 1, 0, 1, 0, "R7");
    phase("R7", 0, 2, 0, 3, 2);
    // R6: two full words, last on the exact boundary
    phase("R6", 0, 0, 0, 8, 1);
    drain();
    check(stall_err == 0, "R9", "stalls while out_ready high", OB*8'(stall_err), '0);
    bp_on = 1;
    phase("R8", 1, 0, 1, 14, 1);
    phase("R8", 2, 1, 0, 11, 1);
    phase("R8", 3, 2, 0, 7, 1);
    drain();
    check(q_data.size() == 0, "R8", "words left undelivered", OB*8'(q_data.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule